// File: doc/BRIEF.md
# Byte-Lane Clock-Gated Register Bank

This block is a 64-bit storage register whose flops are split into eight 8-bit lanes. Each lane receives its own gated clock. The gate for a lane is a level-sensitive latch that is open while the free-running clock is low, followed by an AND of the latch output with the clock. A lane that has no work does not see any clock edges, so its flops stop toggling. Glitches on the enable cannot reach the gated clock.

A lane's enable is formed from three sources: the write request qualified by the operand width, the synchronous clear, and the scan-shift mode. The clear and the scan mode force every lane's clock on. This lets a clear reach lanes that are otherwise idle, and lets the shift chain pass through all 64 flops. A write can carry the full 64-bit word or only the lower 32 bits. A narrow write keeps the upper four lanes frozen, with their clocks stopped.

An asynchronous active-low reset is released through a two-stage synchronizer. While this reset is active, the gate latches are cleared and the flops are cleared.

Top module: `lane_gated_bank`

## Requirements
- R1: While `rst_n` is low, `rd_data` and `scan_out` read zero. After release with no other activity, they stay zero.
- R2: With `wr_req`=1, `width_sel`=1 (full width), `srst`=0 and `scan_en`=0 at a rising clock edge, `rd_data` takes all 64 bits of `wr_data`.
- R3: With `wr_req`=1, `width_sel`=0 (lower half), `srst`=0 and `scan_en`=0 at a rising edge, bits 31:0 take `wr_data[31:0]` and bits 63:32 keep their value.
- R4: With `wr_req`, `srst` and `scan_en` all low at a rising edge, `rd_data` is unchanged.
- R5: With `srst`=1 and `scan_en`=0 at a rising edge, all 64 bits clear to zero, even when `wr_req` is low.
- R6: When `srst` and `wr_req` are both high with `scan_en`=0, the clear wins and the result is zero.
- R7: With `scan_en`=1 at a rising edge, the register shifts by one bit toward the MSB: bit 0 takes `scan_in`, and bit i takes the old bit i-1. `scan_out` always equals bit 63.
- R8: `scan_en` overrides both `srst` and `wr_req`. A shift occurs whatever they are.
- R9: A change of `wr_req`, `width_sel` or `wr_data` during the clock-high phase has no effect on the register. It is reverted before the clock falls.
- R10: A pulse on `wr_req` during the clock-low phase that returns low before the rising edge causes no write.
- R11: The latched enable of every lane gate never changes while the clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_req | input | 1 | Write request |
| width_sel | input | 1 | 1 = full 64-bit write, 0 = lower 32 bits only |
| wr_data | input | 64 | Write data |
| srst | input | 1 | Synchronous clear of all lanes |
| scan_en | input | 1 | Scan shift mode, forces every lane clock on |
| scan_in | input | 1 | Serial input into bit 0 |
| rd_data | output | 64 | Register contents |
| scan_out | output | 1 | Serial output, bit 63 |

## Verification
The bench tries the main function with the following patterns and checks each against a reference model:
- Full-width writes and half-width writes. Comparing these shows whether the upper lanes' clocks really stay stopped.
- Clears issued with no write pending. These show whether the clear reaches lanes whose functional enable is low.
- Clear combined with write, and scan combined with both. These separate the three priorities.
- A 64-step shift with a known pattern. This exposes any break or reordering in the chain between lanes.
- Enable pulses placed in the clock-high phase and enable pulses placed in the clock-low phase. These tell a correctly latched gate apart from a bare AND gate or a latch open in the wrong phase.

A seeded random mix of all of these then runs alongside the directed cases.

// File: rtl/lgb_pkg.sv
package lgb_pkg;
  typedef enum logic {
    WID_HALF = 1'b0,
    WID_FULL = 1'b1
  } width_e;
endpackage

// File: rtl/lgb_rst_sync.sv
module lgb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/lgb_enable_ctrl.sv
module lgb_enable_ctrl #(
  parameter int unsigned NUM_LANES  = 8,
  parameter int unsigned HALF_LANES = NUM_LANES / 2
) (
  input  logic                 wr_req,
  input  lgb_pkg::width_e      width,
  input  logic                 srst,
  input  logic                 scan_en,
  output logic [NUM_LANES-1:0] lane_en
);
  logic [NUM_LANES-1:0] func_en;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    if (g < HALF_LANES) begin : g_low
      assign func_en[g] = wr_req;
    end else begin : g_high
      assign func_en[g] = wr_req && (width == lgb_pkg::WID_FULL);
    end
    // clear and scan must reach every lane, active or idle
    assign lane_en[g] = func_en[g] | srst | scan_en;
  end
endmodule

// File: rtl/lgb_clk_gate.sv
module lgb_clk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en_raw,
  output logic gclk
);
  logic en_lat;

  // open while clk is low; frozen across the high phase
  always_latch begin
    if (!rst_n)   en_lat <= 1'b0;
    else if (!clk) en_lat <= en_raw;
  end

  assign gclk = clk & en_lat;

  // R11: the held enable may only move during the low phase
  always @(en_lat) begin
    if (rst_n) begin
      assert_latch_hold_R11: assert (!clk)
        else $error("latched enable changed while clock high");
    end
  end
endmodule

// File: rtl/lgb_lane_store.sv
module lgb_lane_store #(
  parameter int unsigned LANE_W = 8
) (
  input  logic              gclk,
  input  logic              rst_n,
  input  logic              scan_en,
  input  logic              srst,
  input  logic              chain_in,
  input  logic [LANE_W-1:0] d,
  output logic [LANE_W-1:0] q
);
  logic [LANE_W-1:0] q_nxt;

  // an edge only arrives when this lane is enabled, so no hold path here
  always_comb begin
    if (scan_en)   q_nxt = {q[LANE_W-2:0], chain_in};
    else if (srst) q_nxt = '0;
    else           q_nxt = d;
  end

  always_ff @(posedge gclk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/lane_gated_bank.sv
module lane_gated_bank #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic              width_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              srst,
  input  logic              scan_en,
  input  logic              scan_in,
  output logic [DATA_W-1:0] rd_data,
  output logic              scan_out
);
  localparam int unsigned NUM_LANES  = DATA_W / LANE_W;
  localparam int unsigned HALF_LANES = NUM_LANES / 2;
  localparam int unsigned HALF_W     = HALF_LANES * LANE_W;

  logic                 rst_sync_n;
  logic [NUM_LANES-1:0] lane_en;
  logic [NUM_LANES-1:0] lane_gclk;
  logic [NUM_LANES-1:0] lane_chain;
  logic [NUM_LANES-1:0][LANE_W-1:0] lane_q;
  lgb_pkg::width_e      width;

  assign width = lgb_pkg::width_e'(width_sel);

  lgb_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lgb_enable_ctrl #(.NUM_LANES(NUM_LANES), .HALF_LANES(HALF_LANES)) i_enable_ctrl (
    .wr_req  (wr_req),
    .width   (width),
    .srst    (srst),
    .scan_en (scan_en),
    .lane_en (lane_en)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    if (g == 0) begin : g_head
      assign lane_chain[g] = scan_in;
    end else begin : g_link
      assign lane_chain[g] = lane_q[g-1][LANE_W-1];
    end

    lgb_clk_gate i_gate (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .en_raw (lane_en[g]),
      .gclk   (lane_gclk[g])
    );

    lgb_lane_store #(.LANE_W(LANE_W)) i_store (
      .gclk     (lane_gclk[g]),
      .rst_n    (rst_sync_n),
      .scan_en  (scan_en),
      .srst     (srst),
      .chain_in (lane_chain[g]),
      .d        (wr_data[g*LANE_W +: LANE_W]),
      .q        (lane_q[g])
    );
  end

  assign rd_data  = lane_q;
  assign scan_out = rd_data[DATA_W-1];

  assert_full_write_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_req && width_sel && !srst && !scan_en) |=> (rd_data == $past(wr_data)))
    else $error("full write not loaded");

  assert_half_keeps_upper_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_req && !width_sel && !srst && !scan_en) |=>
      (rd_data[DATA_W-1:HALF_W] == $past(rd_data[DATA_W-1:HALF_W]) &&
       rd_data[HALF_W-1:0] == $past(wr_data[HALF_W-1:0])))
    else $error("half write wrong");

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wr_req && !srst && !scan_en) |=> $stable(rd_data))
    else $error("idle register changed");

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (srst && !scan_en) |=> (rd_data == '0))
    else $error("clear not applied");

  assert_scan_shift_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    scan_en |=> (rd_data == {$past(rd_data[DATA_W-2:0]), $past(scan_in)}))
    else $error("scan shift wrong");
endmodule

// File: tb/test_lane_gated_bank.sv
module test_lane_gated_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_req;
  logic        width_sel;
  logic [63:0] wr_data;
  logic        srst;
  logic        scan_en;
  logic        scan_in;
  logic [63:0] rd_data;
  logic        scan_out;

  int n_cmp  = 0;
  int n_fail = 0;
  logic [63:0] exp_q;

  always #10 clk = ~clk;

  lane_gated_bank i_lane_gated_bank (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .width_sel(width_sel),
    .wr_data(wr_data), .srst(srst), .scan_en(scan_en), .scan_in(scan_in),
    .rd_data(rd_data), .scan_out(scan_out)
  );

  function automatic logic [63:0] model_next(input logic [63:0] cur, input logic w,
      input logic wid, input logic sr, input logic se, input logic si, input logic [63:0] dat);
    if (se)      return {cur[62:0], si};
    else if (sr) return 64'h0;
    else if (w)  return wid ? dat : {cur[63:32], dat[31:0]};
    else         return cur;
  endfunction

  task automatic check(input string req);
    n_cmp++;
    if (rd_data !== exp_q || scan_out !== exp_q[63]) begin
      n_fail++;
      $display("FAIL %s: actual rd_data=%h scan_out=%b expected rd_data=%h scan_out=%b",
               req, rd_data, scan_out, exp_q, exp_q[63]);
    end
  endtask

  // called just after a falling edge; glitch: 0 none, 1 high phase, 2 low phase
  task automatic step(input logic w, input logic wid, input logic sr, input logic se,
      input logic si, input logic [63:0] dat, input int glitch, input string req);
    if (glitch == 2) begin
      wr_req = ~w; width_sel = 1'b1; wr_data = ~dat;
      #3;
    end
    wr_req = w; width_sel = wid; srst = sr; scan_en = se; scan_in = si; wr_data = dat;
    exp_q = model_next(exp_q, w, wid, sr, se, si, dat);
    @(posedge clk);
    if (glitch == 1) begin
      #3;
      wr_req = ~w; width_sel = ~wid; wr_data = ~dat;
      #3;
      wr_req = w; width_sel = wid; wr_data = dat;
    end
    @(negedge clk);
    #1;
    check(req);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] pat;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; wr_req = 0; width_sel = 0; wr_data = '0;
    srst = 0; scan_en = 0; scan_in = 0;
    exp_q = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R1 after release");

    step(1, 1, 0, 0, 0, 64'hDEAD_BEEF_0123_4567, 0, "R2 full write");
    step(1, 0, 0, 0, 0, 64'hFFFF_FFFF_89AB_CDEF, 0, "R3 half write keeps upper");
    step(0, 1, 0, 0, 0, 64'h1111_2222_3333_4444, 0, "R4 idle hold");
    step(0, 0, 1, 0, 0, 64'h0, 0, "R5 clear while idle");
    step(1, 1, 0, 0, 0, 64'hA5A5_5A5A_C3C3_3C3C, 0, "R2 reload");
    step(1, 1, 1, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R6 clear beats write");
    step(1, 1, 0, 0, 0, 64'h0F0F_F0F0_1234_8765, 0, "R2 reload");
    step(0, 1, 0, 0, 0, 64'hFFFF_0000_FFFF_0000, 1, "R9 R11 high-phase glitch no write");
    step(1, 0, 0, 0, 0, 64'h7777_7777_2468_ACE0, 1, "R9 R11 high-phase glitch half write");
    step(0, 1, 0, 0, 0, 64'h1357_9BDF_0000_FFFF, 2, "R10 low-phase glitch no write");

    pat = 64'hC001_D00D_8BAD_F00D;
    for (int i = 0; i < 64; i++) begin
      step(0, 0, 0, 1, pat[63 - i], 64'h0, 0, "R7 scan shift");
    end
    step(1, 1, 1, 1, 1'b1, 64'h0, 0, "R8 scan beats clear and write");
    step(1, 0, 0, 1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R8 scan beats write");

    for (int i = 0; i < 400; i++) begin
      int unsigned mode;
      logic w, wid, sr, se;
      string req;
      mode = $urandom % 16;
      se  = (mode == 0);
      sr  = (mode == 1) || (mode == 2 && ($urandom % 2 == 0));
      w   = (mode >= 5) || (mode == 2);
      wid = ($urandom % 2) == 1;
      if (se)      req = "R7 random scan";
      else if (sr) req = "R5 R6 random clear";
      else if (w)  req = wid ? "R2 random full" : "R3 random half";
      else         req = "R4 random idle";
      step(w, wid, sr, se, ($urandom % 2) == 1, {$urandom, $urandom},
           int'($urandom % 3), req);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end
endmodule